// File: doc/BRIEF.md
# Event-Gated Timer Counter with Capture

This block is a general-purpose up/down counter for timing and event counting. It moves by exactly one step only on clock cycles in which a count strobe is present, so one clock domain can serve both free-running timing (count strobe tied high) and counting of qualified external events. The period limit is programmable. Four direction modes select between a wrapping up-counter, a reloading down-counter and two triangle (up then down) variants. The triangle variants differ only in which turning points raise terminal count.

A three-state controller governs the counter. In Idle the counter is disabled and cleared. In Halted it is configured but not counting. In Running it counts. Idle moves to Halted when the enable input is raised. Halted moves to Running on a start strobe. Running moves back to Halted on a stop strobe. Any state falls to Idle when the enable is dropped. Set the mode and period before raising the enable, then issue a start strobe. A reload strobe sets the count to its starting value, and a capture strobe copies the live count into a capture register. Every result is registered: terminal count, overflow and underflow pulses, and a line output that toggles on each terminal count, together with its complement.

Top module: `evt_timer`

## Requirements
- R1: Parameter CNT_W sets the counter width and is 16 or 32. After reset the count and capture value are 0, the tc_irq, trig_ovf and trig_unf pulses are low, line_o is 0 and line_n_o is 1.
- R2: While cfg_en is low the controller is Idle. Each edge clears the count to 0, sets the direction to up and drives line_o to 0. Start, count and capture strobes are ignored. On the first edge with cfg_en high the controller goes to Halted, and a start strobe in that cycle is ignored.
- R3: In Halted, ev_start without ev_stop moves the controller to Running. Count strobes act only in cycles where the controller is already Running and ev_stop is low. ev_stop moves Running to Halted and keeps the count, and a count strobe in the same cycle is ignored. Stop takes priority over start.
- R4: In Running, each ev_count moves the count by exactly one step, apart from the turning points given in R5 to R8. Without ev_count or ev_reload the count holds.
- R5: Mode 2'b00 (up): when count >= cfg_period, a count step wraps it to 0 and pulses tc_irq and trig_ovf. Otherwise the count increments.
- R6: Mode 2'b01 (down): at count 0, a count step loads cfg_period and pulses tc_irq and trig_unf. Otherwise the count decrements.
- R7: Mode 2'b10 (triangle, bottom only): going up at count >= cfg_period, a step gives cfg_period-1 (0 if the period is 0), turns down and pulses trig_ovf without tc_irq. Going down at count 0, a step gives 1 (0 if the period is 0), turns up and pulses trig_unf and tc_irq.
- R8: Mode 2'b11 (triangle, both ends): the count path is the same as in R7, but tc_irq pulses at both turning points.
- R9: With cfg_en high, ev_reload in any state sets the count to cfg_period in down mode, or in a triangle mode while going down. Otherwise it sets the count to 0. The direction is kept, no pulse is raised, and reload takes priority over a count strobe in the same cycle.
- R10: With cfg_en high, ev_capture loads capture_o with the count value held before that edge, which is the pre-step value when a count step happens in the same cycle. Otherwise capture_o holds.
- R11: tc_irq, trig_ovf and trig_unf are single-cycle registered pulses. Each appears on the same edge as the count value produced by the step that caused it.
- R12: line_o toggles on every edge that raises tc_irq, and line_n_o is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Counter enable; low forces Idle |
| cfg_mode | input | 2 | Direction mode: 00 up, 01 down, 10 triangle bottom-tc, 11 triangle both-tc |
| cfg_period | input | CNT_W | Period limit |
| ev_reload | input | 1 | Reload strobe |
| ev_start | input | 1 | Start strobe |
| ev_stop | input | 1 | Stop strobe |
| ev_count | input | 1 | Count qualifier strobe |
| ev_capture | input | 1 | Capture strobe |
| count_o | output | CNT_W | Live count |
| capture_o | output | CNT_W | Captured count |
| tc_irq | output | 1 | Terminal-count interrupt pulse |
| trig_ovf | output | 1 | Trigger: upper turning point or wrap |
| trig_unf | output | 1 | Trigger: lower turning point or reload from 0 |
| line_o | output | 1 | Line output, toggles on terminal count |
| line_n_o | output | 1 | Complement of line_o |

## Verification
Every output is registered. A strobe sampled at one rising edge shows its effect on count, capture, pulses and line right after that edge, while the effect on the controller state is seen one edge later, as a count that starts or stops moving. The bench drives inputs on the falling edge and compares all outputs against a behavioural reference at the next falling edge, so each result is sampled exactly one edge after its cause. Directed scenarios check the turning points of each mode, start and stop collisions, reload priority and capture of the pre-step value at those same instants.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        MODE_UP    = 2'b00,
        MODE_DOWN  = 2'b01,
        MODE_UPDN1 = 2'b10,
        MODE_UPDN2 = 2'b11
    } evt_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HALT = 2'b01,
        ST_RUN  = 2'b10
    } evt_state_e;

    typedef struct packed {
        logic tc;
        logic ovf;
        logic unf;
    } evt_flags_t;

endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
    import evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic ev_start,
    input  logic ev_stop,
    input  logic ev_count,
    input  logic ev_reload,
    input  logic ev_capture,
    output logic clear_o,
    output logic reload_o,
    output logic step_o,
    output logic capture_o
);

    evt_state_e state_q;
    evt_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: enable, start, stop, disable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_en) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (!cfg_en)                   state_d = ST_IDLE;
                else if (ev_start && !ev_stop) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!cfg_en)      state_d = ST_IDLE;
                else if (ev_stop) state_d = ST_HALT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        clear_o   = !cfg_en;
        reload_o  = cfg_en && ev_reload;
        capture_o = cfg_en && ev_capture;
        step_o    = 1'b0;
        unique case (state_q)
            ST_RUN:  step_o = cfg_en && !ev_stop && ev_count && !ev_reload;
            ST_HALT: step_o = 1'b0;
            ST_IDLE: step_o = 1'b0;
            default: step_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evt_core.sv
module evt_core
    import evt_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             reload_i,
    input  logic             step_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output evt_flags_t       flags_o,
    output evt_flags_t       flags_next_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    evt_mode_e        mode;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dn_q, dn_d;
    evt_flags_t       flg_q, flg_d;
    logic             at_top, at_bot, per_zero, going_dn;
    logic [CNT_W-1:0] below_top, above_bot;

    assign mode      = evt_mode_e'(mode_i);
    assign at_top    = (cnt_q >= period_i);
    assign at_bot    = (cnt_q == ZERO);
    assign per_zero  = (period_i == ZERO);
    assign below_top = per_zero ? ZERO : (period_i - ONE);
    assign above_bot = per_zero ? ZERO : ONE;
    assign going_dn  = (mode == MODE_DOWN) || (mode_i[1] && dn_q);

    always_comb begin
        cnt_d = cnt_q;
        dn_d  = dn_q;
        flg_d = '0;
        if (clear_i) begin
            cnt_d = ZERO;
            dn_d  = 1'b0;
        end else if (reload_i) begin
            cnt_d = going_dn ? period_i : ZERO;
        end else if (step_i) begin
            unique case (mode)
                MODE_UP: begin
                    if (at_top) begin
                        cnt_d     = ZERO;
                        flg_d.tc  = 1'b1;
                        flg_d.ovf = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                MODE_DOWN: begin
                    if (at_bot) begin
                        cnt_d     = period_i;
                        flg_d.tc  = 1'b1;
                        flg_d.unf = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                MODE_UPDN1, MODE_UPDN2: begin
                    if (!dn_q) begin
                        if (at_top) begin
                            cnt_d     = below_top;
                            dn_d      = 1'b1;
                            flg_d.ovf = 1'b1;
                            flg_d.tc  = (mode == MODE_UPDN2);
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end else begin
                        if (at_bot) begin
                            cnt_d     = above_bot;
                            dn_d      = 1'b0;
                            flg_d.unf = 1'b1;
                            flg_d.tc  = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            dn_q  <= 1'b0;
            flg_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            dn_q  <= dn_d;
            flg_q <= flg_d;
        end
    end

    assign cnt_o        = cnt_q;
    assign flags_o      = flg_q;
    assign flags_next_o = flg_d;

endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o
);

    logic [CNT_W-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (take_i) begin
            cap_q <= cnt_i;
        end
    end

    assign cap_o = cap_q;

endmodule

// File: rtl/evt_line.sv
module evt_line (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tc_next_i,
    output logic line_o,
    output logic line_n_o
);

    logic line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else if (clear_i) begin
            line_q <= 1'b0;
        end else if (tc_next_i) begin
            line_q <= !line_q;
        end
    end

    assign line_o   = line_q;
    assign line_n_o = !line_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             ev_reload,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_count,
    input  logic             ev_capture,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             tc_irq,
    output logic             trig_ovf,
    output logic             trig_unf,
    output logic             line_o,
    output logic             line_n_o
);

    logic       clear, reload, step, take;
    evt_flags_t flags, flags_next;

    evt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .ev_start   (ev_start),
        .ev_stop    (ev_stop),
        .ev_count   (ev_count),
        .ev_reload  (ev_reload),
        .ev_capture (ev_capture),
        .clear_o    (clear),
        .reload_o   (reload),
        .step_o     (step),
        .capture_o  (take)
    );

    evt_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .reload_i     (reload),
        .step_i       (step),
        .mode_i       (cfg_mode),
        .period_i     (cfg_period),
        .cnt_o        (count_o),
        .flags_o      (flags),
        .flags_next_o (flags_next)
    );

    evt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .cnt_i  (count_o),
        .cap_o  (capture_o)
    );

    evt_line u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .tc_next_i (flags_next.tc),
        .line_o    (line_o),
        .line_n_o  (line_n_o)
    );

    assign tc_irq   = flags.tc;
    assign trig_ovf = flags.ovf;
    assign trig_unf = flags.unf;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
    import evt_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [1:0]       cfg_mode,
    input logic             ev_reload,
    input logic             ev_count,
    input logic             ev_capture,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] capture_o,
    input logic             tc_irq,
    input logic             trig_ovf,
    input logic             trig_unf,
    input logic             line_o
);

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (count_o == '0 && !line_o)); // R2

    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !ev_count && !ev_reload) |=> $stable(count_o)); // R4

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !ev_reload) |=> (count_o == $past(count_o)
            || count_o == $past(count_o) + 1'b1
            || count_o == $past(count_o) - 1'b1
            || trig_ovf || trig_unf)); // R4

    AST_CAPTURE_PRESTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && ev_capture) |=> (capture_o == $past(count_o))); // R10

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && ev_capture) |=> $stable(capture_o)); // R10

    AST_LINE_TOGGLES_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
        tc_irq |-> (line_o != $past(line_o))); // R12

    AST_UPDN1_TOP_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_ovf && $past(cfg_mode) == MODE_UPDN1) |-> !tc_irq); // R7

    AST_DOWN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ovf |-> ($past(cfg_mode) != MODE_DOWN)); // R6

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_mode   (cfg_mode),
    .ev_reload  (ev_reload),
    .ev_count   (ev_count),
    .ev_capture (ev_capture),
    .count_o    (count_o),
    .capture_o  (capture_o),
    .tc_irq     (tc_irq),
    .trig_ovf   (trig_ovf),
    .trig_unf   (trig_unf),
    .line_o     (line_o)
);

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

    localparam int  W        = 16;
    localparam time TCLK     = 20ns;
    localparam int  WD_LIMIT = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_en = 1'b0;
    logic [1:0]   cfg_mode = 2'b00;
    logic [W-1:0] cfg_period = '0;
    logic         ev_reload = 1'b0, ev_start = 1'b0, ev_stop = 1'b0;
    logic         ev_count = 1'b0, ev_capture = 1'b0;
    logic [W-1:0] count_o, capture_o;
    logic         tc_irq, trig_ovf, trig_unf, line_o, line_n_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(TCLK/2) clk = !clk;

    evt_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_period(cfg_period), .ev_reload(ev_reload), .ev_start(ev_start),
        .ev_stop(ev_stop), .ev_count(ev_count), .ev_capture(ev_capture),
        .count_o(count_o), .capture_o(capture_o), .tc_irq(tc_irq),
        .trig_ovf(trig_ovf), .trig_unf(trig_unf), .line_o(line_o),
        .line_n_o(line_n_o)
    );

    // behavioural reference
    longint m_cnt, m_cap;
    int     m_st;      // 0 idle, 1 halted, 2 running
    bit     m_dn, m_tc, m_ovf, m_unf, m_line;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_cap = 0; m_st = 0; m_dn = 0;
            m_tc = 0; m_ovf = 0; m_unf = 0; m_line = 0;
        end else begin
            longint c, p;
            bit d, t, o, u;
            c = m_cnt; p = cfg_period; d = m_dn; t = 0; o = 0; u = 0;
            if (cfg_en && ev_capture) m_cap = m_cnt;
            if (!cfg_en) begin
                c = 0; d = 0;
            end else if (ev_reload) begin
                c = (cfg_mode == 2'b01 || (cfg_mode[1] && d)) ? p : 0;
            end else if (m_st == 2 && !ev_stop && ev_count) begin
                if (cfg_mode == 2'b00) begin
                    if (c >= p) begin c = 0; t = 1; o = 1; end
                    else c = c + 1;
                end else if (cfg_mode == 2'b01) begin
                    if (c == 0) begin c = p; t = 1; u = 1; end
                    else c = c - 1;
                end else if (!d) begin
                    if (c >= p) begin
                        c = (p > 0) ? p - 1 : 0; d = 1; o = 1; t = (cfg_mode == 2'b11);
                    end else c = c + 1;
                end else begin
                    if (c == 0) begin c = (p > 0) ? 1 : 0; d = 0; u = 1; t = 1; end
                    else c = c - 1;
                end
            end
            if (!cfg_en) m_line = 0;
            else if (t) m_line = !m_line;
            m_cnt = c; m_dn = d; m_tc = t; m_ovf = o; m_unf = u;
            if (!cfg_en) m_st = 0;
            else if (m_st == 0) m_st = 1;
            else if (m_st == 1 && ev_start && !ev_stop) m_st = 2;
            else if (m_st == 2 && ev_stop) m_st = 1;
        end
    end

    function automatic void chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 count",     count_o,   m_cnt);
            chk("R10 capture",  capture_o, m_cap);
            chk("R11 tc_irq",   tc_irq,    m_tc);
            chk("R11 trig_ovf", trig_ovf,  m_ovf);
            chk("R11 trig_unf", trig_unf,  m_unf);
            chk("R12 line_o",   line_o,    m_line);
            chk("R12 line_n_o", line_n_o,  !m_line);
        end
    end

    task automatic ev(input bit rl, input bit st, input bit sp, input bit ct, input bit cp);
        ev_reload = rl; ev_start = st; ev_stop = sp; ev_count = ct; ev_capture = cp;
        @(negedge clk);
        ev_reload = 0; ev_start = 0; ev_stop = 0; ev_count = 0; ev_capture = 0;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset count", count_o, 0);
        chk("R1 reset capture", capture_o, 0);
        chk("R1 reset tc", tc_irq, 0);
        chk("R1 reset line", line_o, 0);
        chk("R1 reset line_n", line_n_o, 1);
        rst_n = 1;
        @(negedge clk);

        // R2: disabled, strobes ignored
        ev(0, 1, 0, 1, 1);
        ev(0, 0, 0, 1, 1);
        chk("R2 idle count", count_o, 0);
        chk("R2 idle capture", capture_o, 0);

        // enable, up mode, period 3
        cfg_mode = 2'b00; cfg_period = 3; cfg_en = 1;
        ev(0, 1, 0, 0, 0);               // start on first enabled edge: ignored
        ev(0, 0, 0, 1, 0);               // halted: count ignored
        chk("R2 start ignored on enable edge", count_o, 0);
        ev(0, 1, 0, 1, 0);               // start + count: count not yet active
        chk("R3 start same-cycle count", count_o, 0);
        ev(0, 0, 0, 1, 0); chk("R5 up 1", count_o, 1);
        ev(0, 0, 0, 1, 0); chk("R5 up 2", count_o, 2);
        ev(0, 0, 0, 1, 0); chk("R5 up 3", count_o, 3);
        ev(0, 0, 0, 1, 0);
        chk("R5 wrap to 0", count_o, 0);
        chk("R5 tc at wrap", tc_irq, 1);
        chk("R5 ovf at wrap", trig_ovf, 1);
        chk("R12 line toggled", line_o, 1);
        ev(0, 0, 0, 0, 0);
        chk("R11 tc one cycle", tc_irq, 0);
        chk("R4 hold without count", count_o, 0);

        // R3 stop
        ev(0, 0, 0, 1, 0);
        ev(0, 0, 1, 1, 0); chk("R3 stop blocks count", count_o, 1);
        ev(0, 0, 0, 1, 0); chk("R3 halted keeps value", count_o, 1);
        ev(0, 1, 1, 0, 0);
        ev(0, 0, 0, 1, 0); chk("R3 stop beats start", count_o, 1);
        ev(0, 1, 0, 0, 0);
        ev(0, 0, 0, 1, 0); chk("R3 restart", count_o, 2);

        // R10 capture pre-step
        ev(0, 0, 0, 1, 1);
        chk("R10 capture pre-step", capture_o, 2);
        chk("R10 count stepped", count_o, 3);

        // R9 reload beats count
        ev(1, 0, 0, 1, 0); chk("R9 reload up to 0", count_o, 0);

        // R6 down mode
        cfg_mode = 2'b01;
        ev(1, 0, 0, 0, 0); chk("R9 reload down to period", count_o, 3);
        ev(0, 0, 0, 1, 0); chk("R6 down 2", count_o, 2);
        ev(0, 0, 0, 1, 0);
        ev(0, 0, 0, 1, 0); chk("R6 down 0", count_o, 0);
        ev(0, 0, 0, 1, 0);
        chk("R6 load period", count_o, 3);
        chk("R6 tc", tc_irq, 1);
        chk("R6 unf", trig_unf, 1);

        // R7 triangle bottom-only
        cfg_mode = 2'b10; cfg_period = 2;
        ev(1, 0, 0, 0, 0); chk("R9 reload tri up", count_o, 0);
        ev(0, 0, 0, 1, 0);
        ev(0, 0, 0, 1, 0); chk("R7 reach top", count_o, 2);
        ev(0, 0, 0, 1, 0);
        chk("R7 turn down", count_o, 1);
        chk("R7 ovf at top", trig_ovf, 1);
        chk("R7 no tc at top", tc_irq, 0);
        ev(0, 0, 0, 1, 0); chk("R7 reach bottom", count_o, 0);
        ev(0, 0, 0, 1, 0);
        chk("R7 turn up", count_o, 1);
        chk("R7 tc at bottom", tc_irq, 1);

        // R8 triangle both ends
        cfg_mode = 2'b11;
        ev(0, 0, 0, 1, 0);
        ev(0, 0, 0, 1, 0);
        chk("R8 turn at top", count_o, 1);
        chk("R8 tc at top", tc_irq, 1);
        ev(1, 0, 0, 0, 0); chk("R9 reload while going down", count_o, 2);

        // R2 disable clears
        cfg_en = 0;
        ev(0, 0, 0, 1, 0);
        chk("R2 disable clears count", count_o, 0);
        chk("R2 disable clears line", line_o, 0);

        // mixed stimulus against the reference
        cfg_en = 1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 63) == 0) cfg_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 127) == 0) cfg_period = W'($urandom_range(0, 7));
            if ($urandom_range(0, 255) == 0) cfg_en = !cfg_en;
            ev_reload  = ($urandom_range(0, 31) == 0);
            ev_start   = ($urandom_range(0, 15) == 0);
            ev_stop    = ($urandom_range(0, 31) == 0);
            ev_count   = ($urandom_range(0, 3) != 0);
            ev_capture = ($urandom_range(0, 7) == 0);
            @(negedge clk);
        end
        ev(0, 0, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule